// File: doc/BRIEF.md
# Byte-Wide Static Memory with Delayed Write Strobe

The block is a four-word, byte-wide static memory. One shared bidirectional data port carries write data into the memory and read data out of it. Three controls steer it: a select, a write request and a read enable. The byte is built from four identical narrow slices. Each slice stores four words of two bits and picks its row through a 2-to-4 decoder. All slices share the address and control lines, and slice k holds data bits 2k+1 and 2k.

A write does not take effect on the next clock edge. A write request seen while the block is idle captures the address and the data on the port. The block then waits a settle interval of DELAY_CYC clock cycles, and after that it raises an internal write strobe for PULSE_CYC cycles. The strobe reaches only the decoded row, so only that row takes the held data. While this sequence runs the block reports busy and ignores any further write request.

A read drives the addressed byte onto the port for as long as select and read enable are high and the write request is low. In every other case the port is released.

Top module: `byte_strobe_sram`

## Requirements
- R1: After reset all four words hold zero, busy is low and the block does not drive the port.
- R2: A request (sel=1, wr_en=1) seen at a clock edge while busy is low captures addr and the port byte. That word reads back the new byte from the cycle that follows the (DELAY_CYC+1)-th clock edge after acceptance. Until then a read returns the old contents.
- R3: busy rises at the accepting edge and stays high for exactly DELAY_CYC+PULSE_CYC cycles. A request held on the port is accepted again at the first edge at which busy is low.
- R4: A write request seen while busy is high has no effect on the stored contents or on the sequence in progress.
- R5: A write changes only the word at the captured address. The other three words keep their values.
- R6: While sel=1, rd_en=1 and wr_en=0, drive_en is high and the port carries the word at addr. The path is combinational, so no clock edge is needed.
- R7: While sel=0 or rd_en=0, drive_en is low and the block leaves the port undriven.
- R8: With sel, wr_en and rd_en all high, the block treats the cycle as a write and does not drive the port.
- R9: Port bits 2k+1 and 2k, for k = 0 to 3, are stored in and returned from slice k. A byte with a distinct value in each bit pair reads back unchanged.
- R10: bus_sample always equals the resolved value on the data port, whoever drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous and release is synchronous |
| sel | input | 1 | Chip select |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Output enable |
| addr | input | 2 | Word address |
| data | inout | 8 | Shared bidirectional data port |
| busy | output | 1 | A write sequence is in progress |
| drive_en | output | 1 | The block is driving the data port |
| bus_sample | output | 8 | Resolved value on the data port |

## Verification
The assertions assume a few things about the environment. The controls are stable between clock edges. While a read is enabled, nothing outside the block drives the port. The port carries a defined byte whenever a write request is presented. The bench meets all three conditions. It changes its inputs just after each rising edge and drives the port only while sel and wr_en are both high. It also leaves every write request low while reset is being released. Within those limits the stimulus covers several cases:
- reads issued while a write is still settling;
- requests made during busy;
- a request held until the block accepts it again;
- a read and a write requested in the same cycle;
- bytes whose four bit pairs all differ.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int SLICE_W = 2;
  localparam int ROWS    = 4;
  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_PULSE} wr_phase_e;
endpackage

// File: rtl/wr_strobe_gen.sv
module wr_strobe_gen #(
  parameter int DELAY_CYC = 3,
  parameter int PULSE_CYC = 2,
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          busy,
  output logic          strobe,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  import sram_pkg::*;
  localparam int MAXC  = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  wr_phase_e          ph, ph_nx;
  logic [CNT_W-1:0]   cnt, cnt_nx;
  logic               cap;

  always_comb begin
    ph_nx  = ph;
    cnt_nx = cnt;
    cap    = 1'b0;
    case (ph)
      PH_IDLE: if (req) begin
        ph_nx  = PH_WAIT;
        cnt_nx = CNT_W'(DELAY_CYC - 1);
        cap    = 1'b1;
      end
      PH_WAIT: if (cnt == '0) begin
        ph_nx  = PH_PULSE;
        cnt_nx = CNT_W'(PULSE_CYC - 1);
      end else begin
        cnt_nx = cnt - 1'b1;
      end
      PH_PULSE: if (cnt == '0) ph_nx = PH_IDLE;
                else cnt_nx = cnt - 1'b1;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      ph  <= ph_nx;
      cnt <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  assign busy   = (ph != PH_IDLE);
  assign strobe = (ph == PH_PULSE);

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy);
  // R4
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && busy) |=> ($stable(addr_q) && $stable(data_q)));
  // R3
  end_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(strobe));
endmodule

// File: rtl/sram_slice.sv
module sram_slice #(
  parameter int ROWS = 4,
  parameter int SW   = 2,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [AW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [SW-1:0] rdata
);
  logic [ROWS-1:0][SW-1:0] words;
  logic [ROWS-1:0]         row_we;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_we[r] = strobe && (waddr == AW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         words[r] <= '0;
      else if (row_we[r]) words[r] <= wdata;
    end
  end

  assign rdata = words[raddr];

  // R5
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_we));
  // R2
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(words));
endmodule

// File: rtl/byte_strobe_sram.sv
module byte_strobe_sram #(
  parameter int DELAY_CYC = 3,
  parameter int PULSE_CYC = 2,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  inout  wire  [DATA_W-1:0] data,
  output logic              busy,
  output logic              drive_en,
  output logic [DATA_W-1:0] bus_sample
);
  import sram_pkg::*;
  localparam int SLICES = DATA_W / SLICE_W;
  localparam int AW     = $clog2(ROWS);

  logic              rs_meta, rs_n;
  logic              strobe;
  logic [AW-1:0]     waddr;
  logic [DATA_W-1:0] wbyte, rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  wr_strobe_gen #(.DELAY_CYC(DELAY_CYC), .PULSE_CYC(PULSE_CYC), .AW(AW), .DW(DATA_W)) i_gen (
    .clk(clk), .rst_n(rs_n), .req(sel && wr_en), .addr_in(addr), .data_in(data),
    .busy(busy), .strobe(strobe), .addr_q(waddr), .data_q(wbyte));

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    sram_slice #(.ROWS(ROWS), .SW(SLICE_W)) i_slice (
      .clk(clk), .rst_n(rs_n), .strobe(strobe), .waddr(waddr),
      .wdata(wbyte[k*SLICE_W +: SLICE_W]), .raddr(addr),
      .rdata(rd_word[k*SLICE_W +: SLICE_W]));
  end

  assign drive_en   = sel && rd_en && !wr_en;
  assign data       = drive_en ? rd_word : {DATA_W{1'bz}};
  assign bus_sample = data;

  // R10
  bus_owner_chk: assert property (@(posedge clk) disable iff (!rs_n)
    drive_en |-> (bus_sample == rd_word));
endmodule

// File: tb/test_byte_strobe_sram.sv
`timescale 1ns/100ps
module test_byte_strobe_sram;
  localparam int D = 3;
  localparam int P = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] a = '0;
  logic [7:0] tv = '0;
  wire  [7:0] data;
  logic busy, drive_en;
  logic [7:0] bus_sample;

  int vectors = 0, miscompares = 0;
  int age = 0;
  logic [1:0] la;
  logic [7:0] ld;
  logic [7:0] mem [4];
  bit done = 0;

  always #2.5 clk = ~clk;

  assign data = (sel && wr) ? tv : 8'bz;

  byte_strobe_sram #(.DELAY_CYC(D), .PULSE_CYC(P)) i_byte_strobe_sram (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr), .rd_en(rd), .addr(a),
    .data(data), .busy(busy), .drive_en(drive_en), .bus_sample(bus_sample));

  // behavioural reference: age counts edges since acceptance
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age = 0;
      for (int i = 0; i < 4; i++) mem[i] = 8'h00;
    end else if (age == 0) begin
      if (sel && wr) begin age = 1; la = a; ld = tv; end
    end else begin
      int nx;
      nx = age + 1;
      if (nx == D + 2) mem[la] = ld;
      age = (nx == D + P + 1) ? 0 : nx;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    logic xd;
    xd = sel && rd && !wr;
    chk(busy == (age != 0), "R3 busy", {7'b0, busy}, {7'b0, age != 0});
    chk(drive_en == xd, (wr ? "R8 drive" : "R6/R7 drive"), {7'b0, drive_en}, {7'b0, xd});
    if (xd) chk(bus_sample === mem[a], "R6 read data", bus_sample, mem[a]);
    else if (sel && wr) chk(bus_sample === tv, "R10 bus sample", bus_sample, tv);
  end

  task automatic cyc(input logic s, input logic w, input logic r, input logic [1:0] ad, input logic [7:0] d);
    @(posedge clk); #1;
    sel = s; wr = w; rd = r; a = ad; tv = d;
  endtask

  task automatic rd_chk(input logic [1:0] ad, input logic [7:0] exp, input string tag);
    cyc(1, 0, 1, ad, 8'h00);
    @(negedge clk); #0.1;
    chk(bus_sample === exp && drive_en, tag, bus_sample, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 2'd0, 8'h00);
  endtask

  initial begin
    #12 rst_n = 1'b1;
    idle(6);
    for (int i = 0; i < 4; i++) rd_chk(i[1:0], 8'h00, "R1 reset contents");
    idle(1);
    @(negedge clk); chk(!busy && !drive_en, "R1 idle state", {6'b0, busy, drive_en}, 8'h00);
    // R2 write, then read the same word while it settles
    cyc(1, 1, 0, 2'd2, 8'hA5);
    // R4 request during busy must be ignored
    cyc(1, 1, 0, 2'd1, 8'h3C);
    for (int i = 0; i < D + P + 2; i++) cyc(1, 0, 1, 2'd2, 8'h00);
    rd_chk(2'd2, 8'hA5, "R2 written word");
    rd_chk(2'd1, 8'h00, "R4 ignored request");
    rd_chk(2'd0, 8'h00, "R5 neighbour untouched");
    rd_chk(2'd3, 8'h00, "R5 neighbour untouched");
    // R9 distinct bit pairs
    cyc(1, 1, 0, 2'd0, 8'b10_01_11_00);
    idle(D + P + 1);
    rd_chk(2'd0, 8'b10_01_11_00, "R9 slice lanes");
    // R8 write and read together
    cyc(1, 1, 1, 2'd3, 8'h5A);
    @(negedge clk); chk(!drive_en, "R8 no drive", {7'b0, drive_en}, 8'h00);
    idle(D + P + 1);
    rd_chk(2'd3, 8'h5A, "R8 treated as write");
    // R7 no drive without select or without read enable
    cyc(0, 0, 1, 2'd3, 8'h00);
    @(negedge clk); chk(!drive_en, "R7 sel low", {7'b0, drive_en}, 8'h00);
    cyc(1, 0, 0, 2'd3, 8'h00);
    @(negedge clk); chk(!drive_en, "R7 rd low", {7'b0, drive_en}, 8'h00);
    // R3 held request is re-accepted once busy drops
    for (int i = 0; i < D + P + 2; i++) cyc(1, 1, 0, 2'd1, 8'hC3);
    idle(D + P + 2);
    rd_chk(2'd1, 8'hC3, "R3 re-accepted write");
    rd_chk(2'd2, 8'hA5, "R5 other word kept");
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule